// File: doc/BRIEF.md
# Single-Route Setting Controller

This block carries one route of a route-based interlocking through its whole life: it accepts a dispatch request, waits until the route's path is vacant and no conflicting route stands in its way, claims the route's points and protecting signals, and waits for the field to confirm them. It then locks the route and opens the route's entry signal. When a train enters, it closes that signal again. When the train has cleared the route, or has come to a stand in front of the exit signal, it gives the route back.

The route's description is fixed at build time as parameter bit masks: which other routes conflict with it, which points it claims and in which position, and which signals protect it. A conflicting route that is already occupied by a train does not block this route, provided the interlocking reports that every element the two routes share has already been released behind that train. The per-route release flag that carries this report comes from outside. Several instances, one per route, are wired together by the surrounding logic, which also models the track.

Top module: `rl_route_ctrl`

## Requirements
- R1: The route mode output uses the codes FREE=0, MARKED=1, ALLOCATING=2, LOCKED=3, USED=4. While reset is held, the mode is FREE and every command output and the release pulse are 0.
- R2: A request moves FREE to MARKED on the next clock edge. A request in any other mode has no effect.
- R3: MARKED moves to ALLOCATING only when every path section is vacant and no conflicting route (3-bit field j of the conflict-mode bus, route j selected by the conflict mask) is in any mode other than FREE or MARKED. Routes outside the mask are ignored.
- R4: A conflicting route in USED does not block allocation when its shared-elements-released flag is 1. When that flag is 0, it blocks.
- R5: On entry to ALLOCATING, each point in the point-use mask is claimed (hold bit 1) and commanded to its required position (0=PLUS, 1=MINUS, taken from the required-position mask). Each signal in the protection mask is held commanded CLOSED (hold bit 1).
- R6: ALLOCATING moves to LOCKED only when every claimed point reports its commanded position and every protecting signal reports CLOSED (aspect 0). A point reporting position code 2 (moving) never matches. The aspect of an unprotected signal is ignored.
- R7: The entry-signal command is OPEN (1) exactly while the mode is LOCKED, and CLOSED (0) otherwise.
- R8: LOCKED moves to USED only when path section 0 (the first section) reports occupied. Occupation of any other section does not move it.
- R9: USED moves to FREE when all path sections are vacant, or when the standstill input is 1.
- R10: The USED-to-FREE move produces a release pulse that lasts exactly one cycle. In the same cycle, all point and protection holds and all point commands return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Dispatch request for this route |
| sect_vacant_i | input | N_SECT | 1 = path section vacant; bit 0 is the entry section |
| conf_mode_i | input | 3*N_ROUTE | Mode of every other route, 3 bits each |
| conf_rel_i | input | N_ROUTE | 1 = elements shared with route j already released |
| pnt_pos_i | input | 2*N_PNT | Reported point positions: 0 PLUS, 1 MINUS, 2 moving |
| sig_act_i | input | N_SIG | Reported signal aspects: 0 CLOSED, 1 OPEN |
| stop_i | input | 1 | Train at a stand before the exit signal |
| pnt_hold_o | output | N_PNT | Point is claimed by this route |
| pnt_cmd_o | output | N_PNT | Commanded point position: 0 PLUS, 1 MINUS |
| prot_hold_o | output | N_SIG | Signal held commanded CLOSED by this route |
| src_sig_o | output | 1 | Entry-signal command: 1 OPEN, 0 CLOSED |
| mode_o | output | 3 | Route mode code |
| released_o | output | 1 | One-cycle pulse when the route is given back |

## Verification
A new dispatch request can arrive in the same cycle in which the route is given back. The route is still USED in that cycle, so the request must be dropped and must not carry over into the FREE state that follows. The bench drives the request together with the last section clearing. It then expects FREE with the release pulse and, one cycle later, FREE again with no pulse. Only a fresh request afterwards may move the route to MARKED.

// File: rtl/rl_route_pkg.sv
// Package: shared route mode codes and reported point position codes.
// Assumes: modes fit in 3 bits; positions fit in 2 bits.
package rl_route_pkg;

    typedef enum logic [2:0] {
        RM_FREE   = 3'd0,
        RM_MARKED = 3'd1,
        RM_ALLOC  = 3'd2,
        RM_LOCKED = 3'd3,
        RM_USED   = 3'd4
    } route_mode_e;

    localparam logic [1:0] POS_PLUS  = 2'd0;
    localparam logic [1:0] POS_MINUS = 2'd1;
    localparam logic [1:0] POS_MOVE  = 2'd2;

    localparam int MODE_W = 3;

endpackage

// File: rtl/rl_alloc_gate.sv
// Module: combinational allocation gate. It decides whether the path is
// vacant and whether any masked conflicting route blocks allocation.
// Assumes: conf_mode_i packs route j at bits [3j+2:3j].
module rl_alloc_gate
    import rl_route_pkg::*;
#(
    parameter int                 N_SECT    = 3,
    parameter int                 N_ROUTE   = 4,
    parameter logic [N_ROUTE-1:0] CONF_MASK = '0
) (
    input  logic [N_SECT-1:0]         sect_vacant_i,
    input  logic [MODE_W*N_ROUTE-1:0] conf_mode_i,
    input  logic [N_ROUTE-1:0]        conf_rel_i,
    output logic                      gate_ok_o,
    output logic                      path_clear_o,
    output logic                      entry_occ_o
);

    logic [N_ROUTE-1:0] blk;

    // One blocking term per route; masked-out routes never block.
    for (genvar j = 0; j < N_ROUTE; j++) begin : g_conf
        logic [MODE_W-1:0] m;
        logic              passive;
        assign m = conf_mode_i[MODE_W*j +: MODE_W];
        // FREE, MARKED, or USED with the shared elements already released
        assign passive = (m == RM_FREE) || (m == RM_MARKED)
                      || ((m == RM_USED) && conf_rel_i[j]);
        assign blk[j]  = CONF_MASK[j] && !passive;
    end

    // Path state summaries used by the sequencer.
    always_comb begin
        path_clear_o = &sect_vacant_i;
        entry_occ_o  = !sect_vacant_i[0];
        gate_ok_o    = path_clear_o && (blk == '0);
    end

endmodule

// File: rtl/rl_field_drive.sv
// Module: holds point and protecting-signal commands and the entry-signal
// command. It also judges whether the field reports the commanded states.
// Assumes: at most one of claim/drop is high in a cycle.
module rl_field_drive
    import rl_route_pkg::*;
#(
    parameter int               N_PNT    = 3,
    parameter int               N_SIG    = 4,
    parameter logic [N_PNT-1:0] PNT_USE  = '0,
    parameter logic [N_PNT-1:0] PNT_REQ  = '0,
    parameter logic [N_SIG-1:0] SIG_PROT = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               claim_i,
    input  logic               open_i,
    input  logic               close_i,
    input  logic               drop_i,
    input  logic [2*N_PNT-1:0] pnt_pos_i,
    input  logic [N_SIG-1:0]   sig_act_i,
    output logic [N_PNT-1:0]   pnt_hold_o,
    output logic [N_PNT-1:0]   pnt_cmd_o,
    output logic [N_SIG-1:0]   prot_hold_o,
    output logic               src_sig_o,
    output logic               fb_ok_o
);

    logic [N_PNT-1:0] pnt_ok;
    logic [N_SIG-1:0] sig_ok;

    // Command registers: load on claim, clear on drop or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || drop_i) begin
            pnt_hold_o  <= '0;
            pnt_cmd_o   <= '0;
            prot_hold_o <= '0;
        end else if (claim_i) begin
            pnt_hold_o  <= PNT_USE;
            pnt_cmd_o   <= PNT_REQ & PNT_USE;
            prot_hold_o <= SIG_PROT;
        end
    end

    // Entry-signal command: open on lock, close on entry or release.
    always_ff @(posedge clk) begin
        if (!rst_n || close_i || drop_i) src_sig_o <= 1'b0;
        else if (open_i)                 src_sig_o <= 1'b1;
    end

    // Per-point feedback match; a moving point never matches.
    for (genvar i = 0; i < N_PNT; i++) begin : g_pnt
        logic [1:0] pos;
        assign pos       = pnt_pos_i[2*i +: 2];
        assign pnt_ok[i] = !pnt_hold_o[i]
                        || (pos == (pnt_cmd_o[i] ? POS_MINUS : POS_PLUS));
    end

    // Per-signal feedback match; a held signal must report CLOSED.
    for (genvar k = 0; k < N_SIG; k++) begin : g_sig
        assign sig_ok[k] = !prot_hold_o[k] || !sig_act_i[k];
    end

    // Overall field confirmation.
    always_comb fb_ok_o = (&pnt_ok) && (&sig_ok);

    // R5: commands stay put between claim and drop
    assert_cmd_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!claim_i && !drop_i) |=> ($stable(pnt_cmd_o) && $stable(pnt_hold_o)
                                   && $stable(prot_hold_o)));

    // R10: a drop leaves no hold behind
    assert_drop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drop_i |=> (pnt_hold_o == '0 && prot_hold_o == '0 && !src_sig_o));

endmodule

// File: rtl/rl_mode_seq.sv
// Module: route mode sequencer. It walks FREE, MARKED, ALLOCATING, LOCKED
// and USED, and emits one-cycle events for the field driver.
// Assumes: gate and feedback inputs are combinational from this cycle.
module rl_mode_seq
    import rl_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        gate_ok_i,
    input  logic        fb_ok_i,
    input  logic        entry_occ_i,
    input  logic        path_clear_i,
    input  logic        stop_i,
    output route_mode_e mode_o,
    output logic        ev_claim_o,
    output logic        ev_lock_o,
    output logic        ev_enter_o,
    output logic        ev_rel_o,
    output logic        released_o
);

    route_mode_e mode_d;

    // Next-mode and event decode.
    always_comb begin
        mode_d     = mode_o;
        ev_claim_o = 1'b0;
        ev_lock_o  = 1'b0;
        ev_enter_o = 1'b0;
        ev_rel_o   = 1'b0;
        case (mode_o)
            RM_FREE:   if (req_i) mode_d = RM_MARKED;
            RM_MARKED: if (gate_ok_i) begin
                           mode_d     = RM_ALLOC;
                           ev_claim_o = 1'b1;
                       end
            RM_ALLOC:  if (fb_ok_i) begin
                           mode_d    = RM_LOCKED;
                           ev_lock_o = 1'b1;
                       end
            RM_LOCKED: if (entry_occ_i) begin
                           mode_d     = RM_USED;
                           ev_enter_o = 1'b1;
                       end
            RM_USED:   if (path_clear_i || stop_i) begin
                           mode_d   = RM_FREE;
                           ev_rel_o = 1'b1;
                       end
            default:   mode_d = RM_FREE;
        endcase
    end

    // Mode and release-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o     <= RM_FREE;
            released_o <= 1'b0;
        end else begin
            mode_o     <= mode_d;
            released_o <= ev_rel_o;
        end
    end

    // R1: mode never leaves the five legal codes
    assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o inside {RM_FREE, RM_MARKED, RM_ALLOC, RM_LOCKED, RM_USED});

    // R2: a request in FREE is always taken
    assert_dispatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == RM_FREE && req_i) |=> mode_o == RM_MARKED);

    // R3: a closed gate keeps the route waiting
    assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == RM_MARKED && !gate_ok_i) |=> mode_o == RM_MARKED);

    // R6: no lock without field confirmation
    assert_lock_fb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == RM_ALLOC && !fb_ok_i) |=> mode_o == RM_ALLOC);

    // R10: the release pulse marks a fresh return to FREE
    assert_rel_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        released_o |-> (mode_o == RM_FREE && $past(mode_o) == RM_USED));

endmodule

// File: rtl/rl_route_ctrl.sv
// Module: top of the single-route setting controller. It ties the
// allocation gate, the mode sequencer and the field command driver together.
// Assumes: the route description is fixed by parameters; the caller supplies
// the other routes' modes and their shared-release flags.
module rl_route_ctrl
    import rl_route_pkg::*;
#(
    parameter int                 N_SECT    = 3,
    parameter int                 N_ROUTE   = 4,
    parameter int                 N_PNT     = 3,
    parameter int                 N_SIG     = 4,
    parameter logic [N_ROUTE-1:0] CONF_MASK = 4'b0110,
    parameter logic [N_PNT-1:0]   PNT_USE   = 3'b011,
    parameter logic [N_PNT-1:0]   PNT_REQ   = 3'b010,
    parameter logic [N_SIG-1:0]   SIG_PROT  = 4'b0101
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_i,
    input  logic [N_SECT-1:0]         sect_vacant_i,
    input  logic [MODE_W*N_ROUTE-1:0] conf_mode_i,
    input  logic [N_ROUTE-1:0]        conf_rel_i,
    input  logic [2*N_PNT-1:0]        pnt_pos_i,
    input  logic [N_SIG-1:0]          sig_act_i,
    input  logic                      stop_i,
    output logic [N_PNT-1:0]          pnt_hold_o,
    output logic [N_PNT-1:0]          pnt_cmd_o,
    output logic [N_SIG-1:0]          prot_hold_o,
    output logic                      src_sig_o,
    output logic [MODE_W-1:0]         mode_o,
    output logic                      released_o
);

    logic        gate_ok, path_clear, entry_occ, fb_ok;
    logic        ev_claim, ev_lock, ev_enter, ev_rel;
    route_mode_e mode;

    rl_alloc_gate #(
        .N_SECT    (N_SECT),
        .N_ROUTE   (N_ROUTE),
        .CONF_MASK (CONF_MASK)
    ) gate_i (
        .sect_vacant_i (sect_vacant_i),
        .conf_mode_i   (conf_mode_i),
        .conf_rel_i    (conf_rel_i),
        .gate_ok_o     (gate_ok),
        .path_clear_o  (path_clear),
        .entry_occ_o   (entry_occ)
    );

    rl_mode_seq seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .gate_ok_i    (gate_ok),
        .fb_ok_i      (fb_ok),
        .entry_occ_i  (entry_occ),
        .path_clear_i (path_clear),
        .stop_i       (stop_i),
        .mode_o       (mode),
        .ev_claim_o   (ev_claim),
        .ev_lock_o    (ev_lock),
        .ev_enter_o   (ev_enter),
        .ev_rel_o     (ev_rel),
        .released_o   (released_o)
    );

    rl_field_drive #(
        .N_PNT    (N_PNT),
        .N_SIG    (N_SIG),
        .PNT_USE  (PNT_USE),
        .PNT_REQ  (PNT_REQ),
        .SIG_PROT (SIG_PROT)
    ) field_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .claim_i     (ev_claim),
        .open_i      (ev_lock),
        .close_i     (ev_enter),
        .drop_i      (ev_rel),
        .pnt_pos_i   (pnt_pos_i),
        .sig_act_i   (sig_act_i),
        .pnt_hold_o  (pnt_hold_o),
        .pnt_cmd_o   (pnt_cmd_o),
        .prot_hold_o (prot_hold_o),
        .src_sig_o   (src_sig_o),
        .fb_ok_o     (fb_ok)
    );

    // Mode code to the port.
    always_comb mode_o = mode;

    // R7: entry signal is open exactly while the route is locked
    assert_src_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        src_sig_o == (mode == RM_LOCKED));

    // R8: only the entry section moves LOCKED to USED
    assert_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RM_LOCKED && sect_vacant_i[0]) |=> mode == RM_LOCKED);

    // R5: holds exist only while the route owns its elements
    assert_hold_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pnt_hold_o != '0) |-> (mode inside {RM_ALLOC, RM_LOCKED, RM_USED}));

endmodule

// File: tb/rl_route_ctrl_tb_top.sv
`timescale 1ns/1ps
module rl_route_ctrl_tb_top;

    typedef struct {
        logic [2:0] mode;
        logic       src;
        logic       rel;
        logic [2:0] ph;
        logic [2:0] pc;
        logic [3:0] sh;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  vac = 3'b111;
    logic [11:0] cmode = {3'd4, 3'd0, 3'd0, 3'd3};
    logic [3:0]  crel = 4'b0000;
    logic [5:0]  ppos = 6'd0;
    logic [3:0]  sact = 4'b0000;
    logic        stop = 1'b0;
    logic [2:0]  ph, pc, mode;
    logic [3:0]  sh;
    logic        src, rel;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    rl_route_ctrl dut_i (
        .clk (clk), .rst_n (rst_n), .req_i (req), .sect_vacant_i (vac),
        .conf_mode_i (cmode), .conf_rel_i (crel), .pnt_pos_i (ppos),
        .sig_act_i (sact), .stop_i (stop), .pnt_hold_o (ph), .pnt_cmd_o (pc),
        .prot_hold_o (sh), .src_sig_o (src), .mode_o (mode), .released_o (rel)
    );

    function automatic exp_t mk(logic [2:0] m, logic s, logic r, bit held,
                                string t);
        exp_t e;
        e.mode = m; e.src = s; e.rel = r; e.tag = t;
        e.ph = held ? 3'b011 : 3'b000;
        e.pc = held ? 3'b010 : 3'b000;
        e.sh = held ? 4'b0101 : 4'b0000;
        return e;
    endfunction

    // Driver: one clock edge, then queue what the ports must show after it.
    task automatic step(exp_t e);
        @(posedge clk);
        #1;
        q.push_back(e);
    endtask

    // Monitor: compare queued expectations at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (mode !== e.mode || src !== e.src || rel !== e.rel ||
                ph !== e.ph || pc !== e.pc || sh !== e.sh) begin
                n_bad++;
                $display("FAIL %s: mode=%0d src=%b rel=%b ph=%b pc=%b sh=%b expected mode=%0d src=%b rel=%b ph=%b pc=%b sh=%b",
                         e.tag, mode, src, rel, ph, pc, sh,
                         e.mode, e.src, e.rel, e.ph, e.pc, e.sh);
            end
        end
    end

    initial begin
        #(20 * 2000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        step(mk(0, 0, 0, 0, "R1 reset state"));
        rst_n = 1'b1;
        step(mk(0, 0, 0, 0, "R1 idle after reset"));
        req = 1'b1;
        step(mk(1, 0, 0, 0, "R2 dispatch from FREE"));
        req = 1'b0; vac = 3'b101;
        step(mk(1, 0, 0, 0, "R3 occupied path blocks"));
        vac = 3'b111; cmode = {3'd4, 3'd0, 3'd3, 3'd3};
        step(mk(1, 0, 0, 0, "R3 locked conflict blocks"));
        cmode = {3'd4, 3'd0, 3'd4, 3'd3};
        step(mk(1, 0, 0, 0, "R4 used conflict unreleased blocks"));
        crel = 4'b0010; req = 1'b1;
        step(mk(2, 0, 0, 1, "R4 R5 released conflict lets allocation start"));
        ppos = {2'd0, 2'd2, 2'd0};
        step(mk(2, 0, 0, 1, "R2 R6 request ignored, moving point"));
        req = 1'b0; ppos = {2'd0, 2'd1, 2'd0}; sact = 4'b0100;
        step(mk(2, 0, 0, 1, "R6 protecting signal still open"));
        sact = 4'b0010;
        step(mk(3, 1, 0, 1, "R6 R7 lock with confirmation"));
        vac = 3'b101;
        step(mk(3, 1, 0, 1, "R8 non-entry section ignored"));
        vac = 3'b100;
        step(mk(4, 0, 0, 1, "R7 R8 train enters"));
        vac = 3'b101;
        step(mk(4, 0, 0, 1, "R9 route not yet cleared"));
        vac = 3'b111; req = 1'b1;
        step(mk(0, 0, 1, 0, "R9 R10 cleared, request in same cycle"));
        req = 1'b0;
        step(mk(0, 0, 0, 0, "R10 R2 pulse one cycle, request dropped"));
        cmode = {3'd4, 3'd0, 3'd0, 3'd3}; crel = 4'b0000; req = 1'b1;
        step(mk(1, 0, 0, 0, "R2 second dispatch"));
        req = 1'b0;
        step(mk(2, 0, 0, 1, "R3 R5 second allocation"));
        step(mk(3, 1, 0, 1, "R6 immediate confirmation"));
        vac = 3'b110;
        step(mk(4, 0, 0, 1, "R8 second entry"));
        stop = 1'b1;
        step(mk(0, 0, 1, 0, "R9 standstill release"));
        stop = 1'b0; vac = 3'b111;
        step(mk(0, 0, 0, 0, "R10 pulse ends"));
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule